// File: doc/BRIEF.md
# DAC Interval Trigger Generator

This block generates single-cycle trigger pulses for a digital-to-analog converter. In counter mode, an interval counter is restarted by an upstream event. That event is either a rising edge on the selected trigger input or, when software triggering is selected, a software strobe. The counter then emits a pulse each time it reaches the programmed interval. After each pulse it wraps to zero and keeps running until the next restart or until the block is disabled.

In external mode the counter is idle. Each rising edge on an asynchronous external trigger pin passes through a synchronizer and an edge detector, and each such edge produces exactly one output pulse.

Software reaches two registers through plain write strobes and always-valid read buses. The control word holds an enable bit and a mode bit. The interval word holds the count limit. No data stream passes through the block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `dac_interval_trig`

## Requirements
- R1: After reset both register read buses read zero and `dac_trig` is low.
- R2: In the control word, bit 0 is enable and bit 1 selects external mode. A write stores only these two bits, and bits 31 to 2 always read zero.
- R3: The interval word stores a 16-bit value in bits 15 to 0, and bits 31 to 16 always read zero.
- R4: While enable is 0, `dac_trig` stays low and restart events are ignored. Clearing enable stops the counter, so setting enable again produces no pulse until a new restart event.
- R5: With external mode off and `sw_sel` low, a rising edge of `trig_in` sampled at clock edge k restarts the counter from zero. With interval N ≥ 1, the first pulse is high for the cycle after clock edge k+N+1.
- R6: After a restart, pulses repeat every N+1 cycles, each exactly one cycle long.
- R7: With `sw_sel` high, a high `sw_trig` sampled at a clock edge restarts the counter in the same way as R5, and `trig_in` edges are ignored. With `sw_sel` low, `sw_trig` is ignored.
- R8: In external mode the counter is not used and `trig_in` has no effect. A rising edge of `ext_trig` gives exactly one pulse. That pulse is high in the third cycle after the first clock edge that samples the new level.
- R9: An interval of 0 produces no pulses in counter mode.
- R10: A restart event sampled at the same edge as a counter match wins. No pulse is emitted for that match, and the counter restarts from zero.
- R11: The largest interval, 65535, gives a first pulse 65536 cycles after the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ival_wr | input | 1 | Write strobe for the interval word |
| wdata | input | 32 | Write data shared by both registers |
| ctrl_rdata | output | 32 | Control word read value |
| ival_rdata | output | 32 | Interval word read value |
| trig_in | input | 1 | Selected upstream trigger, synchronous to clk |
| sw_sel | input | 1 | Selects the software strobe as the restart source |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| dac_trig | output | 1 | Single-cycle trigger pulse to the converter |

## Verification
The bench builds the block with its default parameters: a 32-bit register bus, a 16-bit interval and a two-stage synchronizer. Because the interval keeps its full width, the bench can reach the largest interval and measure a 65536-cycle period, which checks that the counter does not wrap early. The two-stage synchronizer fixes the external-mode latency at three cycles, and that value is checked exactly. Short intervals of 0 to 7 are driven from both restart sources. This makes it cheap to count the pulse trains and the cycle spacing, and to reach the case where a restart collides with a match.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_EXT_BIT = 1;

  typedef struct packed {
    logic ext;
    logic en;
  } dit_ctrl_t;
endpackage

// File: rtl/dit_regs.sv
module dit_regs
  import dit_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int IVAL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ival_wr,
  input  logic [BUS_W-1:0]  wdata,
  output dit_ctrl_t         ctrl,
  output logic [IVAL_W-1:0] ival,
  output logic [BUS_W-1:0]  ctrl_rdata,
  output logic [BUS_W-1:0]  ival_rdata
);
  localparam int CTRL_PAD = BUS_W - 2;
  localparam int IVAL_PAD = BUS_W - IVAL_W;

  dit_ctrl_t         ctrl_q;
  logic [IVAL_W-1:0] ival_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ival_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.en  <= wdata[CTRL_EN_BIT];
        ctrl_q.ext <= wdata[CTRL_EXT_BIT];
      end
      if (ival_wr) ival_q <= wdata[IVAL_W-1:0];
    end
  end

  assign ctrl       = ctrl_q;
  assign ival       = ival_q;
  assign ctrl_rdata = {{CTRL_PAD{1'b0}}, ctrl_q.ext, ctrl_q.en};
  assign ival_rdata = {{IVAL_PAD{1'b0}}, ival_q};

  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_rdata[1:0] == $past(wdata[1:0]));
  a_r3_ival_write: assert property (@(posedge clk) disable iff (!rst_n)
    ival_wr |=> ival == $past(wdata[IVAL_W-1:0]));
endmodule

// File: rtl/dit_edge.sv
module dit_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic sampled;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign sampled = din;
    end else begin : g_sync
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
      assign sampled = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sampled;
  end

  assign rise = sampled & ~prev_q;

  a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         ext,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic         run_q;
  logic [W-1:0] cnt_q;

  assign hit = run_q & en & ~ext & ~restart & (limit != '0) & (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (restart) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (!en || ext) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      if (hit) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0) && run_q);
  a_r4_stop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> (cnt_q == '0) && !run_q);
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en && !ext && !restart && !hit) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r6_wrap_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cnt_q == '0);
endmodule

// File: rtl/dac_interval_trig.sv
module dac_interval_trig
  import dit_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int IVAL_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ival_wr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] ctrl_rdata,
  output logic [BUS_W-1:0] ival_rdata,
  input  logic             trig_in,
  input  logic             sw_sel,
  input  logic             sw_trig,
  input  logic             ext_trig,
  output logic             dac_trig
);
  dit_ctrl_t         ctrl;
  logic [IVAL_W-1:0] ival;
  logic              trig_rise;
  logic              ext_rise;
  logic              restart;
  logic              cnt_hit;
  logic              dac_trig_q;

  dit_regs #(.BUS_W(BUS_W), .IVAL_W(IVAL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ival_wr    (ival_wr),
    .wdata      (wdata),
    .ctrl       (ctrl),
    .ival       (ival),
    .ctrl_rdata (ctrl_rdata),
    .ival_rdata (ival_rdata)
  );

  dit_edge #(.STAGES(0)) u_trig_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (trig_in),
    .rise  (trig_rise)
  );

  dit_edge #(.STAGES(SYNC_STAGES)) u_ext_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_trig),
    .rise  (ext_rise)
  );

  assign restart = ctrl.en & ~ctrl.ext & (sw_sel ? sw_trig : trig_rise);

  dit_counter #(.W(IVAL_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl.en),
    .ext     (ctrl.ext),
    .restart (restart),
    .limit   (ival),
    .hit     (cnt_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dac_trig_q <= 1'b0;
    else        dac_trig_q <= ctrl.en & (ctrl.ext ? ext_rise : cnt_hit);
  end

  assign dac_trig = dac_trig_q;

  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> !dac_trig);
  a_r8_ext_only_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ext && !ext_rise) |=> !dac_trig);
  a_r10_restart_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !ctrl.ext) |=> !dac_trig);
endmodule

// File: tb/dac_interval_trig_tb.sv
`timescale 1ns/1ps
module dac_interval_trig_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic        ival_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] ctrl_rdata;
  logic [31:0] ival_rdata;
  logic        trig_in = 1'b0;
  logic        sw_sel = 1'b0;
  logic        sw_trig = 1'b0;
  logic        ext_trig = 1'b0;
  logic        dac_trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_interval_trig u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ival_wr(ival_wr),
    .wdata(wdata), .ctrl_rdata(ctrl_rdata), .ival_rdata(ival_rdata),
    .trig_in(trig_in), .sw_sel(sw_sel), .sw_trig(sw_trig),
    .ext_trig(ext_trig), .dac_trig(dac_trig)
  );

  typedef struct packed {
    logic [15:0] ival;
    logic        sw;
    logic [7:0]  window;
    logic [7:0]  exp_n;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{16'd1, 1'b0, 8'd20, 8'd10},
    '{16'd2, 1'b0, 8'd21, 8'd7},
    '{16'd5, 1'b1, 8'd30, 8'd5},
    '{16'd0, 1'b0, 8'd40, 8'd0},
    '{16'd3, 1'b1, 8'd17, 8'd4},
    '{16'd7, 1'b0, 8'd64, 8'd8}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [31:0] d);
    ctrl_wr = 1'b1; wdata = d; tick(); ctrl_wr = 1'b0;
  endtask

  task automatic wr_ival(input logic [31:0] d);
    ival_wr = 1'b1; wdata = d; tick(); ival_wr = 1'b0;
  endtask

  task automatic restart_via(input bit use_sw);
    if (use_sw) sw_trig = 1'b1; else trig_in = 1'b1;
    tick();
    sw_trig = 1'b0; trig_in = 1'b0;
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int j = 1; j <= cycles; j++) begin
      tick();
      if (dac_trig) n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check(ctrl_rdata == 0, "R1 ctrl after reset", ctrl_rdata, 0);
    check(ival_rdata == 0, "R1 ival after reset", ival_rdata, 0);
    check(dac_trig == 0, "R1 output after reset", dac_trig, 0);

    // R2 / R3 register layout
    wr_ctrl(32'hFFFF_FFFC);
    check(ctrl_rdata == 0, "R2 upper bits ignored", ctrl_rdata, 0);
    wr_ctrl(32'hFFFF_FFFF);
    check(ctrl_rdata == 32'h3, "R2 two bits stored", ctrl_rdata, 32'h3);
    wr_ctrl(32'h0);
    wr_ival(32'hABCD_1234);
    check(ival_rdata == 32'h0000_1234, "R3 interval low half", ival_rdata, 32'h1234);

    // Vector table: counter mode from both restart sources
    for (int v = 0; v < NVEC; v++) begin
      wr_ival({16'h0, VEC[v].ival});
      sw_sel = VEC[v].sw;
      wr_ctrl(32'h1);
      restart_via(VEC[v].sw);
      n = 0; bad = 0;
      for (int j = 1; j <= int'(VEC[v].window); j++) begin
        bit exp_p;
        tick();
        exp_p = (VEC[v].ival != 0) && (j % (int'(VEC[v].ival) + 1) == 0);
        if (dac_trig) n++;
        if (dac_trig !== exp_p) bad++;
      end
      if (VEC[v].ival == 0)
        check(n == 0, "R9 zero interval silent", n, 0);
      else
        check(bad == 0, VEC[v].sw ? "R7 sw restart pulse spacing" : "R5 edge restart pulse spacing", bad, 0);
      check(n == int'(VEC[v].exp_n), "R6 pulse count", n, VEC[v].exp_n);
      wr_ctrl(32'h0);
      sw_sel = 1'b0;
      tick();
    end

    // R4 disabled: restart ignored
    wr_ival(32'd2);
    restart_via(1'b0);
    count_pulses(12, n);
    check(n == 0, "R4 disabled no pulses", n, 0);
    // R4 clearing enable stops counter; re-enable without restart stays quiet
    wr_ctrl(32'h1);
    restart_via(1'b0);
    tick();
    wr_ctrl(32'h0);
    wr_ctrl(32'h1);
    count_pulses(12, n);
    check(n == 0, "R4 re-enable needs restart", n, 0);

    // R7 source selection: trig_in ignored with sw_sel, sw_trig ignored without
    sw_sel = 1'b1;
    restart_via(1'b0);
    count_pulses(12, n);
    check(n == 0, "R7 trig_in ignored when sw selected", n, 0);
    sw_sel = 1'b0;
    restart_via(1'b1);
    count_pulses(12, n);
    check(n == 0, "R7 sw_trig ignored when edge selected", n, 0);
    wr_ctrl(32'h0);

    // R8 external mode
    wr_ctrl(32'h3);
    restart_via(1'b0);
    count_pulses(12, n);
    check(n == 0, "R8 trig_in ignored in ext mode", n, 0);
    ext_trig = 1'b1;
    bad = 0; n = 0;
    for (int j = 1; j <= 10; j++) begin
      tick();
      if (dac_trig) n++;
      if (dac_trig !== (j == 3)) bad++;
    end
    check(bad == 0, "R8 ext pulse timing", bad, 0);
    check(n == 1, "R8 one pulse per ext edge", n, 1);
    ext_trig = 1'b0;
    count_pulses(6, n);
    ext_trig = 1'b1;
    count_pulses(10, n);
    check(n == 1, "R8 second ext edge", n, 1);
    ext_trig = 1'b0;
    wr_ctrl(32'h0);

    // R10 restart collides with a match
    wr_ival(32'd3);
    sw_sel = 1'b1;
    wr_ctrl(32'h1);
    restart_via(1'b1);
    count_pulses(3, n);
    check(n == 0, "R10 no early pulse", n, 0);
    sw_trig = 1'b1;
    tick();
    sw_trig = 1'b0;
    check(dac_trig == 0, "R10 match suppressed by restart", dac_trig, 0);
    bad = 0;
    for (int j = 5; j <= 8; j++) begin
      tick();
      if (dac_trig !== (j == 8)) bad++;
    end
    check(bad == 0, "R10 counter restarted from zero", bad, 0);
    wr_ctrl(32'h0);
    sw_sel = 1'b0;

    // R11 largest interval
    wr_ival(32'h0000_FFFF);
    wr_ctrl(32'h1);
    restart_via(1'b0);
    n = 0;
    for (int j = 1; j <= 70000; j++) begin
      tick();
      if (dac_trig) begin
        n = j;
        break;
      end
    end
    check(n == 65536, "R11 max interval period", n, 65536);
    wr_ctrl(32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule